// File: doc/BRIEF.md
# Neighbor Load-Sharing Task Router

This block is the last distribution stage in front of a linear row of processing elements. Every element owns one task queue inside the router. A task arrives on the lane of its home element. Before the task is written into any queue, the router compares the pending-task count of the home queue with the counts of the queues up to `HOPS` positions to each side. The task goes to the least loaded queue that still has room. Each queue entry stores the id of the home element, so the element that does the work can send the result back to the home accumulator bank.

The elements are arranged in switch groups of `GROUP`. Edge links let an element at a group border reach the nearest elements of the adjacent group. With `EDGE_LINKS` cleared, sharing stays inside a group. Several lanes can present tasks in the same cycle. They are resolved in ascending lane order, and each lane sees the slots already claimed by the lanes before it. A task is held on its lane (ready low) only when every queue it may use is full. The element side reads the head of its own queue and pops it.

Top module: `nbr_share_router`

## Requirements
- R1: After reset every queue is empty, every `pe_valid_o` bit is 0 and every `in_ready_o` bit is 1.
- R2: When the home queue's count is no larger than that of any eligible candidate, the task is written to the home queue.
- R3: A task is written to the eligible queue with the smallest count among the home queue and the queues within `HOPS` positions on each side. Queues further away are never used.
- R4: When counts are equal, the order of preference is home, then the nearer distance, then the lower index at the same distance (the left neighbor before the right one).
- R5: Each queue entry carries the data of the task and the lane index of its home element. `pe_home_o` of a queue shows the home id of its head entry.
- R6: Lanes near either end of the array only consider queues with indices 0 to N_PE-1.
- R7: A queue holding DEPTH entries is never chosen. A lane whose candidates are all full drives `in_ready_o` low, and its task is not written. Pops in the same cycle do not free slots for that cycle's choice.
- R8: Lanes presenting tasks in the same cycle are resolved in ascending lane order. Each lane counts the slots claimed by the lanes before it, so two tasks never take the same last slot. The total number of queued entries changes by exactly the accepted tasks minus the effective pops.
- R9: Each queue is first-in first-out. A task claimed earlier in lane order in the same cycle lies ahead of a later one. A pop on an empty queue has no effect.
- R10: With `EDGE_LINKS` set, a task can be written across a group border into the adjacent group's queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | N_PE | Task present on lane i (home element i) |
| in_data_i | input | N_PE*DW | Task payload, lane i at bits [i*DW +: DW] |
| in_ready_o | output | N_PE | Lane i task is accepted this cycle if valid |
| pe_valid_o | output | N_PE | Queue i holds at least one entry |
| pe_data_o | output | N_PE*DW | Head payload of queue i |
| pe_home_o | output | N_PE*IDW | Home element id of the head entry of queue i |
| pe_pop_i | input | N_PE | Element i removes its queue head |

## Verification
The bench goes after the tie order. A design that prefers the right neighbor, or a farther neighbor, puts a task in a different queue, and that queue's head changes visibly. It fills the whole window around one lane to force a stall. A router that ignores fullness overwrites entries, and one that stalls too early drops ready while room is left. It makes two lanes compete for the last slot of a queue, which exposes a router that uses the registered counts without adding same-cycle claims. A long random phase with pops, including pops on empty queues, exposes broken ordering, underflowing counters, wrong home tags and wrong handling at the array ends and group borders.

// File: rtl/nbr_share_pkg.sv
package nbr_share_pkg;
  // Candidate order: k=0 home, odd k left at distance (k+1)/2, even k right at k/2
  function automatic int cand_offset(input int k);
    if (k == 0) return 0;
    else if (k % 2 == 1) return -((k + 1) / 2);
    else return k / 2;
  endfunction
endpackage

// File: rtl/nbr_share_select.sv
module nbr_share_select #(
  parameter int N_PE       = 8,
  parameter int HOPS       = 2,
  parameter int DEPTH      = 4,
  parameter int GROUP      = 4,
  parameter int EDGE_LINKS = 1,
  parameter int CW         = 3,
  localparam int NCAND     = 2 * HOPS + 1
) (
  input  logic [N_PE*CW-1:0]   load_i,
  input  logic [N_PE-1:0]      valid_i,
  output logic [N_PE-1:0]      ready_o,
  output logic [N_PE*N_PE-1:0] push_o   // bit [q*N_PE+l]: lane l writes queue q
);
  always_comb begin
    int ld [N_PE];
    int best;
    int j;
    for (int p = 0; p < N_PE; p++) ld[p] = int'(load_i[p*CW +: CW]);
    ready_o = '0;
    push_o  = '0;
    for (int l = 0; l < N_PE; l++) begin
      best = -1;
      for (int k = 0; k < NCAND; k++) begin
        j = l + nbr_share_pkg::cand_offset(k);
        if (j >= 0 && j < N_PE) begin
          if (EDGE_LINKS != 0 || (j / GROUP) == (l / GROUP)) begin
            if (ld[j] < DEPTH) begin
              // strict compare keeps the earlier candidate on ties
              if (best < 0) best = j;
              else if (ld[j] < ld[best]) best = j;
            end
          end
        end
      end
      ready_o[l] = (best >= 0);
      if (valid_i[l] && best >= 0) begin
        push_o[best*N_PE + l] = 1'b1;
        ld[best] = ld[best] + 1;
      end
    end
  end
endmodule

// File: rtl/nbr_share_queue.sv
module nbr_share_queue #(
  parameter int N_LANE = 8,
  parameter int DEPTH  = 4,   // power of two, >= 2
  parameter int DW     = 8,
  parameter int IDW    = 3,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_LANE-1:0]    push_i,
  input  logic [N_LANE*DW-1:0] lane_data_i,
  input  logic                 pop_i,
  output logic                 valid_o,
  output logic [DW-1:0]        data_o,
  output logic [IDW-1:0]       home_o,
  output logic [CW-1:0]        cnt_o
);
  typedef struct packed {
    logic [IDW-1:0] home;
    logic [DW-1:0]  data;
  } ent_t;

  ent_t          mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] slot [N_LANE];
  logic [CW-1:0] n_push;
  logic          do_pop;

  // lanes land in ascending order behind the write pointer
  always_comb begin
    n_push = '0;
    for (int l = 0; l < N_LANE; l++) begin
      slot[l] = wr_q + AW'(n_push);
      if (push_i[l]) n_push = n_push + CW'(1);
    end
  end

  assign do_pop = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_q + AW'(do_pop);
      wr_q  <= wr_q + AW'(n_push);
      cnt_q <= cnt_q + n_push - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < N_LANE; l++) begin
      if (push_i[l]) mem_q[slot[l]] <= '{home: IDW'(l), data: lane_data_i[l*DW +: DW]};
    end
  end

  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q].data;
  assign home_o  = mem_q[rd_q].home;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/nbr_share_router.sv
module nbr_share_router #(
  parameter int N_PE       = 8,
  parameter int HOPS       = 2,
  parameter int DEPTH      = 4,
  parameter int DW         = 8,
  parameter int GROUP      = 4,
  parameter int EDGE_LINKS = 1,
  localparam int IDW       = $clog2(N_PE),
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_PE-1:0]     in_valid_i,
  input  logic [N_PE*DW-1:0]  in_data_i,
  output logic [N_PE-1:0]     in_ready_o,
  output logic [N_PE-1:0]     pe_valid_o,
  output logic [N_PE*DW-1:0]  pe_data_o,
  output logic [N_PE*IDW-1:0] pe_home_o,
  input  logic [N_PE-1:0]     pe_pop_i
);
  logic [N_PE*CW-1:0]   load_flat;
  logic [N_PE*N_PE-1:0] push_mask;

  nbr_share_select #(
    .N_PE(N_PE), .HOPS(HOPS), .DEPTH(DEPTH), .GROUP(GROUP),
    .EDGE_LINKS(EDGE_LINKS), .CW(CW)
  ) u_sel (
    .load_i (load_flat),
    .valid_i(in_valid_i),
    .ready_o(in_ready_o),
    .push_o (push_mask)
  );

  for (genvar q = 0; q < N_PE; q++) begin : g_q
    nbr_share_queue #(
      .N_LANE(N_PE), .DEPTH(DEPTH), .DW(DW), .IDW(IDW)
    ) u_q (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (push_mask[q*N_PE +: N_PE]),
      .lane_data_i(in_data_i),
      .pop_i      (pe_pop_i[q]),
      .valid_o    (pe_valid_o[q]),
      .data_o     (pe_data_o[q*DW +: DW]),
      .home_o     (pe_home_o[q*IDW +: IDW]),
      .cnt_o      (load_flat[q*CW +: CW])
    );
  end
endmodule

// File: rtl/nbr_share_checker.sv
module nbr_share_checker #(
  parameter int N_PE  = 8,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_PE-1:0]    in_valid_i,
  input logic [N_PE-1:0]    in_ready_o,
  input logic [N_PE-1:0]    pe_valid_o,
  input logic [N_PE-1:0]    pe_pop_i,
  input logic [N_PE*CW-1:0] load_flat
);
  int   total, acc_n, pop_n;
  logic live_q;

  always_comb begin
    total = 0;
    for (int p = 0; p < N_PE; p++) total += int'(load_flat[p*CW +: CW]);
    acc_n = $countones(in_valid_i & in_ready_o);
    pop_n = $countones(pe_pop_i & pe_valid_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  AST_CONSERVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> total == $past(total) + $past(acc_n) - $past(pop_n)); // R8

  AST_LANE0_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(load_flat[0 +: CW]) < DEPTH) |-> in_ready_o[0]); // R7

  for (genvar p = 0; p < N_PE; p++) begin : g_p
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(load_flat[p*CW +: CW]) <= DEPTH); // R7
    AST_EMPTY_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_flat[p*CW +: CW] == '0) |-> !pe_valid_o[p]); // R9
    AST_POP_EMPTY_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && !pe_valid_o[p]) |=> load_flat[p*CW +: CW] >= $past(load_flat[p*CW +: CW])); // R9
  end
endmodule

bind nbr_share_router nbr_share_checker #(
  .N_PE(N_PE), .DEPTH(DEPTH), .CW(CW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o),
  .pe_valid_o(pe_valid_o),
  .pe_pop_i  (pe_pop_i),
  .load_flat (load_flat)
);

// File: tb/nbr_share_router_test.sv
module nbr_share_router_test;
  localparam int N    = 8;
  localparam int HOPS = 2;
  localparam int DEP  = 4;
  localparam int DW   = 8;
  localparam int IDW  = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  in_valid_i = '0;
  logic [N*DW-1:0] in_data_i = '0;
  logic [N-1:0]  in_ready_o;
  logic [N-1:0]  pe_valid_o;
  logic [N*DW-1:0] pe_data_o;
  logic [N*IDW-1:0] pe_home_o;
  logic [N-1:0]  pe_pop_i = '0;

  nbr_share_router uut (.*);

  always #2 clk_i = ~clk_i;

  int mq [N][$];
  int sel_l [N];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Reference choice and comparison against the current outputs
  task automatic model_cmp();
    int ld [N];
    for (int p = 0; p < N; p++) ld[p] = mq[p].size();
    for (int l = 0; l < N; l++) begin
      int b = -1;
      for (int d = 0; d <= HOPS; d++) begin
        for (int s = 0; s < 2; s++) begin
          int j = (s == 0) ? l - d : l + d;
          if (d == 0 && s == 1) continue;
          if (j < 0 || j >= N) continue;
          if (ld[j] >= DEP) continue;
          if (b < 0 || ld[j] < ld[b]) b = j;
        end
      end
      sel_l[l] = b;
      chk(in_ready_o[l] == (b >= 0), "R7", $sformatf("ready lane %0d", l), int'(in_ready_o[l]), int'(b >= 0));
      if (in_valid_i[l] && b >= 0) ld[b]++;
    end
    for (int p = 0; p < N; p++) begin
      chk(pe_valid_o[p] == (mq[p].size() > 0), "R9", $sformatf("valid pe %0d", p),
          int'(pe_valid_o[p]), int'(mq[p].size() > 0));
      if (mq[p].size() > 0) begin
        chk(int'(pe_data_o[p*DW +: DW]) == (mq[p][0] & 255), "R3", $sformatf("data pe %0d", p),
            int'(pe_data_o[p*DW +: DW]), mq[p][0] & 255);
        chk(int'(pe_home_o[p*IDW +: IDW]) == (mq[p][0] >> 8), "R5", $sformatf("home pe %0d", p),
            int'(pe_home_o[p*IDW +: IDW]), mq[p][0] >> 8);
      end
    end
  endtask

  task automatic model_upd();
    for (int p = 0; p < N; p++) if (pe_pop_i[p] && mq[p].size() > 0) void'(mq[p].pop_front());
    for (int l = 0; l < N; l++)
      if (in_valid_i[l] && sel_l[l] >= 0) mq[sel_l[l]].push_back(l * 256 + int'(in_data_i[l*DW +: DW]));
  endtask

  // inputs set at negedge; compare, clock, update model, back to negedge
  task automatic step();
    #1 model_cmp();
    @(posedge clk_i);
    model_upd();
    @(negedge clk_i);
    in_valid_i = '0;
    pe_pop_i   = '0;
  endtask

  task automatic put(input int l, input int d);
    in_valid_i[l] = 1'b1;
    in_data_i[l*DW +: DW] = DW'(d);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(pe_valid_o == '0, "R1", "valid after reset", int'(pe_valid_o), 0);
    chk(in_ready_o == '1, "R1", "ready after reset", int'(in_ready_o), 255);
    @(negedge clk_i);

    // pops on empty queues do nothing (R9)
    pe_pop_i = '1; step();
    chk(pe_valid_o == '0, "R9", "pop on empty", int'(pe_valid_o), 0);

    // R2: empty array, task stays home
    put(3, 8'h11); step();
    chk(pe_valid_o == 8'b0000_1000, "R2", "home pick", int'(pe_valid_o), 8);
    // R4: tie between 2 and 4 -> left neighbor
    put(3, 8'h22); step();
    chk(pe_valid_o == 8'b0000_1100, "R4", "left tie", int'(pe_valid_o), 12);
    chk(int'(pe_home_o[2*IDW +: IDW]) == 3, "R5", "home tag on pe2", int'(pe_home_o[2*IDW +: IDW]), 3);
    // R10: 2 and 3 loaded, pe4 in next group wins
    put(3, 8'h33); step();
    chk(pe_valid_o == 8'b0001_1100, "R10", "cross group", int'(pe_valid_o), 28);
    chk(int'(pe_data_o[4*DW +: DW]) == 8'h33, "R10", "cross group data", int'(pe_data_o[4*DW +: DW]), 8'h33);

    // fill window 1..5 (20 slots, 3 used)
    for (int i = 0; i < 17; i++) begin put(3, 8'h40 + i); step(); end
    put(3, 8'h99);
    #1;
    chk(in_ready_o[3] == 1'b0, "R7", "window full stall", int'(in_ready_o[3]), 0);
    chk(in_ready_o[0] == 1'b1, "R6", "lane0 uses pe0", int'(in_ready_o[0]), 1);
    chk(in_ready_o[7] == 1'b1, "R3", "lane7 beyond reach", int'(in_ready_o[7]), 1);
    step();
    chk(pe_valid_o == 8'b0011_1110, "R7", "stalled task not written", int'(pe_valid_o), 62);

    // three into pe0, then lanes 0 and 1 contend for its last slot
    for (int i = 0; i < 3; i++) begin put(0, 8'h50 + i); step(); end
    put(0, 8'h60); put(1, 8'h61);
    #1;
    chk(in_ready_o[0] == 1'b1, "R8", "lane0 takes last slot", int'(in_ready_o[0]), 1);
    chk(in_ready_o[1] == 1'b0, "R8", "lane1 sees slot taken", int'(in_ready_o[1]), 0);
    step();
    chk(int'(pe_data_o[0 +: DW]) == 8'h50, "R9", "pe0 head order", int'(pe_data_o[0 +: DW]), 8'h50);

    // random traffic with pops, including pops on empty queues
    for (int c = 0; c < 4000; c++) begin
      for (int l = 0; l < N; l++) begin
        if ($urandom_range(0, 99) < 45) put(l, int'($urandom_range(0, 255)));
        pe_pop_i[l] = ($urandom_range(0, 99) < 50);
      end
      step();
    end
    // drain
    for (int c = 0; c < 2 * DEP; c++) begin pe_pop_i = '1; step(); end
    chk(pe_valid_o == '0, "R9", "drained", int'(pe_valid_o), 0);

    done = 1;
    report();
  end
endmodule